// File: doc/BRIEF.md
# Zero-Operand Stack Execution Unit

This block executes a small instruction set. Operands are kept on an internal last-in-first-out stack, and only the top of that stack can be reached. The two arithmetic instructions carry no operand field. Each takes the two uppermost entries, removes both and leaves the result in their place. The only instructions that name anything are the two that move data between the stack and a synchronous data memory, and each of them carries a single address.

An outside sequencer presents one opcode and one address per clock. It holds off while `busy` is high. A load from memory needs a second cycle because the memory answers one cycle after it sees an address. Illegal stack accesses (overflow or underflow) leave the stack intact and raise a sticky error flag. A halt instruction freezes the unit until reset. Reset is asynchronous and active-low, and its release is synchronised inside the block, so the unit starts accepting opcodes two clock edges after `rst_n` rises.

Top module: `stack_exec_unit`

## Requirements
- R1: Opcode `1` (load) with address A drives `mem_addr`=A in its accept cycle. In the following cycle, `busy` is 1 and the memory word read from A is pushed as the new top entry.
- R2: Opcode `2` (store) with address A drives `mem_addr`=A, `mem_wdata`=top entry and `mem_we`=1 for that one cycle, then removes the top entry.
- R3: Opcode `3` (sum) removes the two uppermost entries and pushes their sum modulo 2^DATA_W. No overflow indication is given.
- R4: Opcode `4` (difference) removes the two uppermost entries and pushes (entry below top) minus (top) modulo 2^DATA_W.
- R5: Entries leave the stack in the reverse of the order they entered it. No instruction addresses an interior entry.
- R6: A load while the stack already holds DEPTH entries sets `err`, performs no push, and does not assert `busy`.
- R7: A store on an empty stack, or a sum or difference with fewer than two entries, sets `err`, leaves the stack unchanged and keeps `mem_we` at 0.
- R8: Once set, `err` stays at 1 until reset.
- R9: Any opcode presented while `busy` is 1 is ignored.
- R10: Opcode `5` sets `halted`. From then until reset, every opcode is ignored: no memory write, no stack change, no `busy`, no new error.
- R11: After reset, `busy`, `err`, `halted` and `mem_we` are 0 and the stack is empty.
- R12: Opcodes `0`, `6` and `7` do nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_code | input | 3 | Instruction opcode presented this cycle |
| op_addr | input | ADDR_W | Memory address used by load and store |
| mem_rdata | input | DATA_W | Read data from synchronous memory (one-cycle latency) |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_we | output | 1 | Memory write enable |
| busy | output | 1 | Load wait cycle in progress; opcodes ignored |
| err | output | 1 | Sticky stack overflow/underflow flag |
| halted | output | 1 | Halt flag; set until reset |

## Verification
The bench builds the unit with DATA_W=4, DEPTH=4 and ADDR_W=5. The narrow data width makes every operand pair reachable, so sum and difference are swept over all 256 pairs and both wrap directions appear. The shallow stack means a few loads are enough to fill it. That brings overflow, underflow with zero and one entry, reverse-order retrieval, and opcodes presented during the load wait within a short run. The halt and spare-opcode cases are observed through memory writes and later stores.

// File: rtl/stk_pkg.sv
package stk_pkg;

  typedef enum logic [2:0] {
    OP_NOP  = 3'd0,
    OP_LOAD = 3'd1,
    OP_STOR = 3'd2,
    OP_SUM  = 3'd3,
    OP_DIFF = 3'd4,
    OP_HALT = 3'd5
  } op_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_FILL = 1'b1
  } st_e;

endpackage

// File: rtl/stk_alu.sv
module stk_alu #(
  parameter int DATA_W = 16
) (
  input  logic              sub,
  input  logic [DATA_W-1:0] below,
  input  logic [DATA_W-1:0] top,
  output logic [DATA_W-1:0] y
);

  // Result wraps modulo 2^DATA_W; the carry is discarded.
  always_comb begin
    if (sub) y = below - top;
    else     y = below + top;
  end

endmodule

// File: rtl/stk_store.sv
module stk_store #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push_en,
  input  logic                         pop_en,
  input  logic                         fold_en,
  input  logic [DATA_W-1:0]            wdata,
  output logic [DATA_W-1:0]            top,
  output logic [DATA_W-1:0]            below,
  output logic [$clog2(DEPTH+1)-1:0]   count
);

  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int IDX_W = $clog2(DEPTH);

  logic [DATA_W-1:0] ent_q [DEPTH];
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              cnt_en;
  logic [IDX_W-1:0]  top_idx, below_idx;

  // Next occupancy: push adds one, pop or fold removes one.
  always_comb begin
    cnt_en = push_en | pop_en | fold_en;
    cnt_d  = cnt_q;
    if (push_en)               cnt_d = cnt_q + CNT_W'(1);
    else if (pop_en | fold_en) cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // One write enable per entry: a push writes slot count, a fold
  // overwrites slot count-2 with the arithmetic result.
  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic wr_en;
    always_comb begin
      wr_en = (push_en && (cnt_q == CNT_W'(g))) ||
              (fold_en && ({1'b0, cnt_q} == (CNT_W+1)'(g + 2)));
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     ent_q[g] <= '0;
      else if (wr_en) ent_q[g] <= wdata;
    end
  end

  always_comb begin
    top_idx   = IDX_W'(cnt_q - CNT_W'(1));
    below_idx = IDX_W'(cnt_q - CNT_W'(2));
    top       = ent_q[top_idx];
    below     = ent_q[below_idx];
    count     = cnt_q;
  end

  // R6
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH));

  // R1
  push_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_en |=> top == $past(wdata));

  // R5
  pop_reveal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop_en |=> top == $past(below));

  // R3
  fold_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fold_en |=> cnt_q == $past(cnt_q) - CNT_W'(1));

endmodule

// File: rtl/stk_ctrl.sv
module stk_ctrl
  import stk_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [2:0]                  op_code,
  input  logic [ADDR_W-1:0]           op_addr,
  input  logic [DATA_W-1:0]           mem_rdata,
  input  logic [$clog2(DEPTH+1)-1:0]  count,
  input  logic [DATA_W-1:0]           top,
  input  logic [DATA_W-1:0]           alu_y,
  output logic                        alu_sub,
  output logic                        push_en,
  output logic                        pop_en,
  output logic                        fold_en,
  output logic [DATA_W-1:0]           stk_wdata,
  output logic [ADDR_W-1:0]           mem_addr,
  output logic [DATA_W-1:0]           mem_wdata,
  output logic                        mem_we,
  output logic                        busy,
  output logic                        err,
  output logic                        halted
);

  localparam int CNT_W = $clog2(DEPTH + 1);

  st_e              st_q, st_d;
  logic [ADDR_W-1:0] addr_q;
  logic             addr_en;
  logic             err_q, err_d;
  logic             halt_q, halt_d;
  logic             full, empty, pair;

  always_comb begin
    full  = (count == CNT_W'(DEPTH));
    empty = (count == '0);
    pair  = (count >= CNT_W'(2));
  end

  // Next-state and decode
  always_comb begin
    st_d    = st_q;
    err_d   = err_q;
    halt_d  = halt_q;
    addr_en = 1'b0;
    push_en = 1'b0;
    pop_en  = 1'b0;
    fold_en = 1'b0;
    mem_we  = 1'b0;
    if (st_q == ST_FILL) begin
      push_en = 1'b1;
      st_d    = ST_IDLE;
    end else if (!halt_q) begin
      case (op_e'(op_code))
        OP_LOAD: begin
          if (full) err_d = 1'b1;
          else begin
            st_d    = ST_FILL;
            addr_en = 1'b1;
          end
        end
        OP_STOR: begin
          if (empty) err_d = 1'b1;
          else begin
            mem_we = 1'b1;
            pop_en = 1'b1;
          end
        end
        OP_SUM, OP_DIFF: begin
          if (!pair) err_d = 1'b1;
          else       fold_en = 1'b1;
        end
        OP_HALT: halt_d = 1'b1;
        default: ;
      endcase
    end
  end

  always_comb begin
    alu_sub   = (op_code == OP_DIFF);
    stk_wdata = (st_q == ST_FILL) ? mem_rdata : alu_y;
    mem_addr  = (st_q == ST_FILL) ? addr_q : op_addr;
    mem_wdata = top;
    busy      = (st_q == ST_FILL);
    err       = err_q;
    halted    = halt_q;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      err_q  <= 1'b0;
      halt_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      err_q  <= err_d;
      halt_q <= halt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr_q <= '0;
    else if (addr_en) addr_q <= op_addr;
  end

  // R9
  single_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !busy);

  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);

  // R10
  halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> (!mem_we && !busy && $stable(count)));

  // R7
  no_empty_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> count != '0);

  // R2
  store_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> count == $past(count) - CNT_W'(1));

endmodule

// File: rtl/stack_exec_unit.sv
module stack_exec_unit #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        op_code,
  input  logic [ADDR_W-1:0] op_addr,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we,
  output logic              busy,
  output logic              err,
  output logic              halted
);

  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [1:0]        rsync_q;
  logic              core_rst_n;
  logic              push_en, pop_en, fold_en, alu_sub;
  logic [DATA_W-1:0] stk_wdata, top, below, alu_y;
  logic [CNT_W-1:0]  count;

  // Asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign core_rst_n = rsync_q[1];

  stk_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk     (clk),
    .rst_n   (core_rst_n),
    .push_en (push_en),
    .pop_en  (pop_en),
    .fold_en (fold_en),
    .wdata   (stk_wdata),
    .top     (top),
    .below   (below),
    .count   (count)
  );

  stk_alu #(.DATA_W(DATA_W)) u_alu (
    .sub   (alu_sub),
    .below (below),
    .top   (top),
    .y     (alu_y)
  );

  stk_ctrl #(.DATA_W(DATA_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (core_rst_n),
    .op_code   (op_code),
    .op_addr   (op_addr),
    .mem_rdata (mem_rdata),
    .count     (count),
    .top       (top),
    .alu_y     (alu_y),
    .alu_sub   (alu_sub),
    .push_en   (push_en),
    .pop_en    (pop_en),
    .fold_en   (fold_en),
    .stk_wdata (stk_wdata),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_we    (mem_we),
    .busy      (busy),
    .err       (err),
    .halted    (halted)
  );

endmodule

// File: tb/stack_exec_unit_test.sv
`timescale 1ns/1ps
module stack_exec_unit_test;

  localparam int DW = 4;
  localparam int DP = 4;
  localparam int AW = 5;
  localparam logic [2:0] NOP = 3'd0, LD = 3'd1, ST = 3'd2,
                         SUM = 3'd3, DIF = 3'd4, HLT = 3'd5;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [2:0]    opc;
  logic [AW-1:0] adr;
  logic [DW-1:0] mem_rdata;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic          mem_we, busy, err, halted;
  logic [DW-1:0] mem [32];

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  stack_exec_unit #(.DATA_W(DW), .DEPTH(DP), .ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .op_code(opc), .op_addr(adr),
    .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_we(mem_we), .busy(busy), .err(err), .halted(halted)
  );

  // Synchronous memory model, one-cycle read latency
  always @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= mem_wdata;
    mem_rdata <= mem[mem_addr];
  end

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    opc = NOP;
    adr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic issue(input logic [2:0] c, input logic [AW-1:0] a);
    @(negedge clk);
    opc = c;
    adr = a;
    @(negedge clk);
    opc = NOP;
  endtask

  // Load from a; during the wait cycle present junk opcode jc/ja.
  task automatic load(input logic [AW-1:0] a, input int exp_busy,
                      input logic [2:0] jc, input logic [AW-1:0] ja,
                      input string tag);
    @(negedge clk);
    opc = LD;
    adr = a;
    @(negedge clk);
    if (exp_busy != 0) chk(tag, int'(busy), 1);
    else               chk(tag, int'(busy), 0);
    opc = jc;
    adr = ja;
    @(negedge clk);
    opc = NOP;
  endtask

  initial begin
    for (int i = 0; i < 32; i++) mem[i] = (i < 16) ? DW'(i) : 4'hA;
    rst_n = 1'b0;
    opc = NOP;
    adr = '0;
    do_reset();

    // R11: reset state
    chk("R11 busy", int'(busy), 0);
    chk("R11 err", int'(err), 0);
    chk("R11 halted", int'(halted), 0);
    chk("R11 mem_we", int'(mem_we), 0);

    // R3, R4, R1, R2: all operand pairs
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        load(AW'(a), 1, NOP, '0, "R1 busy");
        load(AW'(b), 1, NOP, '0, "R1 busy");
        issue(SUM, '0);
        issue(ST, 5'd16);
        chk("R3 sum", int'(mem[16]), (a + b) % 16);
        load(AW'(a), 1, NOP, '0, "R1 busy");
        load(AW'(b), 1, NOP, '0, "R1 busy");
        issue(DIF, '0);
        issue(ST, 5'd17);
        chk("R4 diff", int'(mem[17]), (a - b + 16) % 16);
      end
    end
    chk("R8 no spurious err", int'(err), 0);

    // R2: write strobe timing and data on a store
    load(5'd9, 1, NOP, '0, "R1 busy");
    @(negedge clk);
    opc = ST;
    adr = 5'd18;
    #1;
    chk("R2 mem_we", int'(mem_we), 1);
    chk("R2 mem_addr", int'(mem_addr), 18);
    chk("R2 mem_wdata", int'(mem_wdata), 9);
    @(negedge clk);
    opc = NOP;
    #1;
    chk("R2 we one cycle", int'(mem_we), 0);

    // R5, R6, R9: fill, overflow, junk during wait
    do_reset();
    mem[25] = 4'hA;
    load(5'd1, 1, ST, 5'd25, "R1 busy");
    load(5'd2, 1, SUM, '0, "R1 busy");
    load(5'd3, 1, LD, 5'd7, "R1 busy");
    load(5'd4, 1, NOP, '0, "R1 busy");
    chk("R9 junk store ignored", int'(mem[25]), 10);
    chk("R9 no err from junk", int'(err), 0);
    load(5'd5, 0, NOP, '0, "R6 no busy when full");
    chk("R6 err on full", int'(err), 1);
    issue(ST, 5'd16);
    issue(ST, 5'd17);
    issue(ST, 5'd18);
    issue(ST, 5'd19);
    chk("R5 lifo 1st", int'(mem[16]), 4);
    chk("R5 lifo 2nd", int'(mem[17]), 3);
    chk("R5 lifo 3rd", int'(mem[18]), 2);
    chk("R5 lifo 4th", int'(mem[19]), 1);
    mem[20] = 4'hA;
    issue(ST, 5'd20);
    chk("R7 empty store no write", int'(mem[20]), 10);
    chk("R8 err held", int'(err), 1);

    // R7: arithmetic with one entry, stack kept
    do_reset();
    load(5'd7, 1, NOP, '0, "R1 busy");
    issue(SUM, '0);
    chk("R7 sum underflow err", int'(err), 1);
    issue(DIF, '0);
    issue(ST, 5'd21);
    chk("R7 stack unchanged", int'(mem[21]), 7);
    chk("R8 err held", int'(err), 1);

    // R7: store on empty stack
    do_reset();
    mem[22] = 4'hA;
    issue(ST, 5'd22);
    chk("R7 store empty err", int'(err), 1);
    chk("R7 store empty no write", int'(mem[22]), 10);

    // R12: spare opcodes do nothing
    do_reset();
    load(5'd5, 1, NOP, '0, "R1 busy");
    issue(3'd6, 5'd3);
    issue(3'd7, 5'd3);
    issue(NOP, 5'd3);
    issue(ST, 5'd23);
    chk("R12 spare opcodes", int'(mem[23]), 5);
    chk("R12 no err", int'(err), 0);

    // R10: halt freezes the unit
    do_reset();
    load(5'd3, 1, NOP, '0, "R1 busy");
    issue(HLT, '0);
    chk("R10 halted", int'(halted), 1);
    mem[24] = 4'hA;
    issue(ST, 5'd24);
    chk("R10 store ignored", int'(mem[24]), 10);
    load(5'd6, 0, NOP, '0, "R10 load ignored");
    issue(SUM, '0);
    chk("R10 no err", int'(err), 0);
    chk("R10 still halted", int'(halted), 1);
    do_reset();
    chk("R11 halt cleared", int'(halted), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule